// File: doc/BRIEF.md
# Multi-width UART FIFO access port

This block connects a 32-bit host register bus to the transmit and receive FIFOs of one UART channel. On its bulk data location, one host access moves between one and four bytes, one per enabled byte lane. Writes push bytes into the transmit FIFO. Reads pop bytes from the receive FIFO. Bytes are packed little-endian, with the lowest enabled lane holding the oldest byte. A paired receive location returns each received byte next to the error flags captured with it. The flags travel through the receive FIFO together with the byte, so no separate status read is needed.

A legacy holding location moves a single byte per access on lane 0 only. Software on that path reads a line-status location first, which shows the flags of the head byte without popping it, and then reads the byte. The host marks the first beat of every burst. A burst is capped at a total byte budget, and beats past the cap are refused without touching either FIFO. On the line side, the serial logic pushes received bytes with their flags and takes transmit bytes one at a time.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset both FIFOs are empty, `line_tx_avail`, `line_rx_full` and `tx_overflow` are 0, and a line-status read returns 0x20.
- R2: A write to the bulk data location (`bus_loc`=0) pushes one transmit byte per enabled lane. Lower lanes are pushed first, and the line side receives them in that order.
- R3: A read of the bulk data location fills the enabled lanes from low to high with the oldest receive bytes and pops exactly that many.
- R4: When fewer receive bytes are stored than lanes are requested, the surplus lanes read 0 and no pop is made for them.
- R5: A paired read (`bus_loc`=1) fills each enabled 16-bit half (lanes 1:0 or 3:2) with one entry: data in bits 7:0, parity error in bit 8, framing error in bit 9, break in bit 10, zeros above. In a 32-bit paired read the older entry is in the low half.
- R6: Transmit bytes that do not fit in the FIFO are dropped while the earlier bytes of the same access are kept. The drop sets `tx_overflow`, which stays set until a line-status read.
- R7: The holding location (`bus_loc`=2) moves only lane 0, one byte per access. The line-status location (`bus_loc`=3) pops nothing and returns, in bits 7:0, {overflow, tx full, tx empty, rx non-empty, 0, break, framing, parity}, where the flags are those of the head receive byte, or 0 if the FIFO is empty.
- R8: A beat is acknowledged only if the burst's byte total, counted from the last beat with `bus_first`=1 and including this beat, stays within `BURST_LIMIT`. A refused beat has `bus_ack`=0, read data 0, and no FIFO effect.
- R9: `bus_ack` and `bus_rdata` are valid in the strobe cycle, and all pushes and pops take effect at that clock edge. `line_tx_avail` and `line_rx_full` change in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Host access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_loc | input | 2 | 0 bulk data, 1 paired receive, 2 holding, 3 line status |
| bus_lanes | input | 4 | Byte lane enables |
| bus_first | input | 1 | First beat of a burst |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Beat accepted |
| bus_rdata | output | 32 | Read data |
| line_rx_valid | input | 1 | Received byte available from the line |
| line_rx_byte | input | 8 | Received byte |
| line_rx_flags | input | 3 | {break, framing, parity} for the byte |
| line_rx_full | output | 1 | Receive FIFO full |
| line_tx_take | input | 1 | Line side takes the head transmit byte |
| line_tx_byte | output | 8 | Head transmit byte |
| line_tx_avail | output | 1 | Transmit FIFO non-empty |
| tx_overflow | output | 1 | Sticky transmit drop flag |

## Verification
The bench builds the block with `FIFO_DEPTH`=8 and `BURST_LIMIT`=64. The shallow FIFO makes a partial transmit overflow reachable in three accesses: seven bytes stored, then a two-byte write. The stated burst budget keeps the refusal point at its real value, which the bench reaches with a run of four-byte status reads followed by odd-sized beats that land exactly on the limit and just past it.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;

    localparam int BUS_LANES = 4;

    typedef enum logic [1:0] {
        LOC_BULK  = 2'd0,
        LOC_PAIR  = 2'd1,
        LOC_HOLD  = 2'd2,
        LOC_LSTAT = 2'd3
    } loc_e;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_ent_t;

    function automatic int clamp_avail(input int have, input int cap);
        return (have > cap) ? cap : have;
    endfunction

endpackage

// File: rtl/uart_port_fifo.sv
module uart_port_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    parameter  int NPUSH = 1,
    parameter  int NPOP  = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int PSW   = $clog2(NPUSH + 1),
    localparam int POW   = $clog2(NPOP + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PSW-1:0]             push_n,
    input  logic [NPUSH-1:0][W-1:0]    push_data,
    input  logic [POW-1:0]             pop_n,
    output logic [NPOP-1:0][W-1:0]     peek,
    output logic [CW-1:0]              count,
    output logic [CW-1:0]              free
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    generate
        for (genvar g = 0; g < NPOP; g++) begin : g_peek
            assign peek[g] = mem[AW'(rd_ptr + AW'(g))];
        end
    endgenerate

    assign free = CW'(DEPTH) - count;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPUSH; i++) begin
            if (PSW'(i) < push_n) begin
                mem[AW'(wr_ptr + AW'(i))] <= push_data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= AW'(rd_ptr + AW'(pop_n));
            wr_ptr <= AW'(wr_ptr + AW'(push_n));
            count  <= CW'(count + CW'(push_n) - CW'(pop_n));
        end
    end

    // R9: occupancy never exceeds the storage
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R4: never pops more than is stored
    a_r4_pop_within: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= count);
    // R6: never pushes beyond free space
    a_r6_push_within: assert property (@(posedge clk) disable iff (rst)
        CW'(push_n) <= free);

endmodule

// File: rtl/uart_port_burst.sv
module uart_port_burst #(
    parameter  int LIMIT = 64,
    localparam int BW    = $clog2(LIMIT + 5)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       first,
    input  logic [2:0] nbytes,
    output logic       accept
);

    logic [BW-1:0] total_q;
    logic [BW-1:0] base;
    logic [BW-1:0] sum;

    assign base   = first ? '0 : total_q;
    assign sum    = BW'(base + BW'(nbytes));
    assign accept = (sum <= BW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
        end else if (strobe && accept) begin
            total_q <= sum;
        end
    end

    // R8: the running total never passes the budget
    a_r8_total_cap: assert property (@(posedge clk) disable iff (rst)
        total_q <= BW'(LIMIT));

endmodule

// File: rtl/uart_port_lanes.sv
module uart_port_lanes
    import uart_port_pkg::*;
#(
    parameter int CW = 5
) (
    input  loc_e                     loc,
    input  logic                     write,
    input  logic [BUS_LANES-1:0]     lanes,
    input  logic [8*BUS_LANES-1:0]   wdata,
    input  rx_ent_t [BUS_LANES-1:0]  rx_peek,
    input  logic [CW-1:0]            rx_count,
    input  logic [CW-1:0]            tx_free,
    input  logic                     tx_full,
    input  logic                     ovf_q,
    output logic [2:0]               rx_pop_n,
    output logic [2:0]               tx_push_n,
    output logic [BUS_LANES-1:0][7:0] tx_push_data,
    output logic [8*BUS_LANES-1:0]   rdata,
    output logic                     ovf_set,
    output logic                     ovf_clr
);

    logic [BUS_LANES-1:0] eff;
    int                   k;
    int                   avail;
    int                   room;

    always_comb begin
        eff          = (loc == LOC_HOLD) ? {{(BUS_LANES-1){1'b0}}, lanes[0]} : lanes;
        avail        = clamp_avail(int'(rx_count), BUS_LANES);
        room         = clamp_avail(int'(tx_free), BUS_LANES);
        k            = 0;
        rx_pop_n     = '0;
        tx_push_n    = '0;
        tx_push_data = '0;
        rdata        = '0;
        ovf_set      = 1'b0;
        ovf_clr      = 1'b0;
        case (loc)
            LOC_BULK, LOC_HOLD: begin
                if (write) begin
                    for (int i = 0; i < BUS_LANES; i++) begin
                        if (eff[i]) begin
                            tx_push_data[k] = wdata[8*i +: 8];
                            k = k + 1;
                        end
                    end
                    tx_push_n = 3'((k > room) ? room : k);
                    ovf_set   = (k > room);
                end else begin
                    for (int i = 0; i < BUS_LANES; i++) begin
                        if (eff[i] && (k < avail)) begin
                            rdata[8*i +: 8] = rx_peek[k].data;
                            k = k + 1;
                        end
                    end
                    rx_pop_n = 3'(k);
                end
            end
            LOC_PAIR: begin
                if (!write) begin
                    for (int j = 0; j < BUS_LANES / 2; j++) begin
                        if ((lanes[2*j +: 2] == 2'b11) && (k < avail)) begin
                            rdata[16*j +: 16] = {5'b0, rx_peek[k]};
                            k = k + 1;
                        end
                    end
                    rx_pop_n = 3'(k);
                end
            end
            default: begin
                if (!write) begin
                    rdata[7:0] = {ovf_q, tx_full, (tx_free == CW'(2**(CW-1))),
                                  (avail != 0), 1'b0,
                                  (avail != 0) ? {rx_peek[0].brk, rx_peek[0].frm,
                                                  rx_peek[0].par} : 3'b000};
                    ovf_clr    = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import uart_port_pkg::*;
#(
    parameter  int FIFO_DEPTH  = 16,
    parameter  int BURST_LIMIT = 64,
    localparam int CW          = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_strobe,
    input  logic        bus_write,
    input  logic [1:0]  bus_loc,
    input  logic [3:0]  bus_lanes,
    input  logic        bus_first,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic [31:0] bus_rdata,
    input  logic        line_rx_valid,
    input  logic [7:0]  line_rx_byte,
    input  logic [2:0]  line_rx_flags,
    output logic        line_rx_full,
    input  logic        line_tx_take,
    output logic [7:0]  line_tx_byte,
    output logic        line_tx_avail,
    output logic        tx_overflow
);

    logic                       accept;
    logic [2:0]                 nbytes;
    logic [CW-1:0]              rx_count, rx_free, tx_count, tx_free;
    logic [BUS_LANES-1:0][10:0] rx_peek_raw;
    rx_ent_t [BUS_LANES-1:0]    rx_peek;
    rx_ent_t                    rx_in;
    logic [0:0][7:0]            tx_peek;
    logic [2:0]                 map_pop_n, map_push_n;
    logic [BUS_LANES-1:0][7:0]  map_push_data;
    logic [31:0]                map_rdata;
    logic                       map_ovf_set, map_ovf_clr;
    logic [2:0]                 rx_pop_n, tx_push_n;
    logic                       rx_push, tx_pop;
    logic                       rd_ok, wr_ok;
    logic                       ovf_q;

    assign nbytes  = 3'($countones(bus_lanes));
    assign bus_ack = bus_strobe && accept;
    assign rd_ok   = bus_ack && !bus_write;
    assign wr_ok   = bus_ack && bus_write;

    uart_port_burst #(.LIMIT(BURST_LIMIT)) u_burst (
        .clk    (clk),
        .rst    (rst),
        .strobe (bus_strobe),
        .first  (bus_first),
        .nbytes (nbytes),
        .accept (accept)
    );

    generate
        for (genvar g = 0; g < BUS_LANES; g++) begin : g_rx_cast
            assign rx_peek[g] = rx_ent_t'(rx_peek_raw[g]);
        end
    endgenerate

    uart_port_lanes #(.CW(CW)) u_lanes (
        .loc          (loc_e'(bus_loc)),
        .write        (bus_write),
        .lanes        (bus_lanes),
        .wdata        (bus_wdata),
        .rx_peek      (rx_peek),
        .rx_count     (rx_count),
        .tx_free      (tx_free),
        .tx_full      (tx_free == '0),
        .ovf_q        (ovf_q),
        .rx_pop_n     (map_pop_n),
        .tx_push_n    (map_push_n),
        .tx_push_data (map_push_data),
        .rdata        (map_rdata),
        .ovf_set      (map_ovf_set),
        .ovf_clr      (map_ovf_clr)
    );

    assign rx_pop_n  = rd_ok ? map_pop_n : 3'd0;
    assign tx_push_n = wr_ok ? map_push_n : 3'd0;
    assign bus_rdata = rd_ok ? map_rdata : 32'd0;

    assign rx_push = line_rx_valid && (rx_free != '0);
    assign rx_in   = '{brk: line_rx_flags[2], frm: line_rx_flags[1],
                       par: line_rx_flags[0], data: line_rx_byte};
    assign tx_pop  = line_tx_take && (tx_count != '0);

    uart_port_fifo #(.DEPTH(FIFO_DEPTH), .W(11), .NPUSH(1), .NPOP(BUS_LANES)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_n    (rx_push),
        .push_data (rx_in),
        .pop_n     (rx_pop_n),
        .peek      (rx_peek_raw),
        .count     (rx_count),
        .free      (rx_free)
    );

    uart_port_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .NPUSH(BUS_LANES), .NPOP(1)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_n    (tx_push_n),
        .push_data (map_push_data),
        .pop_n     (tx_pop),
        .peek      (tx_peek),
        .count     (tx_count),
        .free      (tx_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (wr_ok && map_ovf_set) begin
            ovf_q <= 1'b1;
        end else if (rd_ok && map_ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign line_tx_byte  = tx_peek[0];
    assign line_tx_avail = (tx_count != '0);
    assign line_rx_full  = (rx_free == '0);
    assign tx_overflow   = ovf_q;

    // R8: a refused beat leaves both FIFOs as they were
    a_r8_refused_still: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_ack && !line_rx_valid && !line_tx_take)
        |=> ($stable(rx_count) && $stable(tx_count)));
    // R6: the drop flag holds until a line-status read
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (tx_overflow && !(bus_ack && !bus_write && bus_loc == 2'd3))
        |=> tx_overflow);
    // R9: transmit data appears only the cycle after a host write
    a_r9_avail_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(line_tx_avail) |-> $past(bus_ack && bus_write));

endmodule

// File: tb/test_uart_fifo_port.sv
module test_uart_fifo_port;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_strobe = 1'b0, bus_write = 1'b0, bus_first = 1'b0;
    logic [1:0]  bus_loc = 2'd0;
    logic [3:0]  bus_lanes = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        line_rx_valid = 1'b0;
    logic [7:0]  line_rx_byte = 8'd0;
    logic [2:0]  line_rx_flags = 3'd0;
    logic        line_rx_full;
    logic        line_tx_take = 1'b0;
    logic [7:0]  line_tx_byte;
    logic        line_tx_avail;
    logic        tx_overflow;

    int total = 0;
    int bad   = 0;
    logic        ak;
    logic [31:0] rd;
    logic        pre_avail;

    always #(CLK_NS/2) clk = ~clk;

    uart_fifo_port #(.FIFO_DEPTH(8), .BURST_LIMIT(64)) i_uart_fifo_port (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic [1:0] loc, input logic wr, input logic [3:0] ln,
                       input logic fst, input logic [31:0] wd);
        @(negedge clk);
        bus_strobe = 1'b1; bus_write = wr; bus_loc = loc;
        bus_lanes = ln; bus_first = fst; bus_wdata = wd;
        #1;
        ak = bus_ack; rd = bus_rdata; pre_avail = line_tx_avail;
        @(posedge clk); #1;
        bus_strobe = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] loc, input logic [3:0] ln,
                          input logic [31:0] exp, input string tag);
        bus(loc, 1'b0, ln, 1'b1, 32'd0);
        check(ak === 1'b1 && rd === exp, tag, rd, exp);
    endtask

    task automatic line_push(input logic [7:0] b, input logic [2:0] f);
        @(negedge clk);
        line_rx_valid = 1'b1; line_rx_byte = b; line_rx_flags = f;
        @(posedge clk); #1;
        line_rx_valid = 1'b0;
    endtask

    task automatic drain_one(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(line_tx_avail === 1'b1 && line_tx_byte === exp, tag,
              {23'd0, line_tx_avail, line_tx_byte}, {24'd1, exp});
        line_tx_take = 1'b1;
        @(posedge clk); #1;
        line_tx_take = 1'b0;
    endtask

    task automatic t_reset;
        check(line_tx_avail === 1'b0, "R1 tx avail", line_tx_avail, 0);
        check(line_rx_full === 1'b0, "R1 rx full", line_rx_full, 0);
        check(tx_overflow === 1'b0, "R1 overflow", tx_overflow, 0);
        rd_chk(2'd3, 4'b0001, 32'h20, "R1 status word");
    endtask

    task automatic t_tx_multi;
        bus(2'd0, 1'b1, 4'b0111, 1'b1, 32'h00C3B2A1);
        check(pre_avail === 1'b0, "R9 avail same cycle", pre_avail, 0);
        check(line_tx_avail === 1'b1, "R9 avail next cycle", line_tx_avail, 1);
        drain_one(8'hA1, "R2 lane0 first");
        drain_one(8'hB2, "R2 lane1");
        drain_one(8'hC3, "R2 lane2");
        bus(2'd0, 1'b1, 4'b1010, 1'b1, 32'hD400E500);
        drain_one(8'hE5, "R2 sparse lane1");
        drain_one(8'hD4, "R2 sparse lane3");
        check(line_tx_avail === 1'b0, "R2 drained", line_tx_avail, 0);
    endtask

    task automatic t_rx_multi;
        line_push(8'h11, 3'd0); line_push(8'h22, 3'd0); line_push(8'h33, 3'd0);
        line_push(8'h44, 3'd0); line_push(8'h55, 3'd0);
        rd_chk(2'd0, 4'b1111, 32'h44332211, "R3 four bytes");
        rd_chk(2'd0, 4'b0001, 32'h00000055, "R3 one byte");
        rd_chk(2'd3, 4'b0001, 32'h20, "R3 rx now empty");
    endtask

    task automatic t_rx_short;
        line_push(8'h66, 3'd0); line_push(8'h77, 3'd0);
        rd_chk(2'd0, 4'b1111, 32'h00007766, "R4 short read zero lanes");
        line_push(8'h88, 3'd0);
        rd_chk(2'd0, 4'b0001, 32'h00000088, "R4 no extra pop");
    endtask

    task automatic t_pair;
        line_push(8'h5A, 3'b001); line_push(8'hA5, 3'b100); line_push(8'h3C, 3'b010);
        rd_chk(2'd1, 4'b1111, 32'h04A5015A, "R5 two pairs");
        rd_chk(2'd1, 4'b0011, 32'h0000023C, "R5 one pair");
        rd_chk(2'd1, 4'b1100, 32'h00000000, "R5 empty pair");
    endtask

    task automatic t_legacy;
        line_push(8'h99, 3'b010);
        rd_chk(2'd3, 4'b0001, 32'h32, "R7 status shows head flags");
        rd_chk(2'd3, 4'b0001, 32'h32, "R7 status does not pop");
        rd_chk(2'd2, 4'b1111, 32'h00000099, "R7 hold lane0 only");
        rd_chk(2'd3, 4'b0001, 32'h20, "R7 hold popped one");
        bus(2'd2, 1'b1, 4'b1111, 1'b1, 32'h44332211);
        drain_one(8'h11, "R7 hold write one byte");
        check(line_tx_avail === 1'b0, "R7 hold write no more", line_tx_avail, 0);
    endtask

    task automatic t_ovf;
        bus(2'd0, 1'b1, 4'b1111, 1'b1, 32'h04030201);
        bus(2'd0, 1'b1, 4'b0111, 1'b1, 32'h00070605);
        check(tx_overflow === 1'b0, "R6 no overflow yet", tx_overflow, 0);
        bus(2'd0, 1'b1, 4'b0011, 1'b1, 32'h0000BBAA);
        check(tx_overflow === 1'b1, "R6 overflow set", tx_overflow, 1);
        repeat (3) @(posedge clk);
        check(tx_overflow === 1'b1, "R6 overflow sticky", tx_overflow, 1);
        rd_chk(2'd3, 4'b0001, 32'hC0, "R6 status overflow and full");
        check(tx_overflow === 1'b0, "R6 cleared by status read", tx_overflow, 0);
        for (int i = 1; i <= 7; i++) drain_one(8'(i), "R6 kept bytes");
        drain_one(8'hAA, "R6 partial fit kept");
        check(line_tx_avail === 1'b0, "R6 extra byte dropped", line_tx_avail, 0);
    endtask

    task automatic t_burst;
        for (int i = 0; i < 15; i++) begin
            bus(2'd3, 1'b0, 4'b1111, (i == 0), 32'd0);
            check(ak === 1'b1, "R8 beat within budget", ak, 1);
        end
        line_push(8'hE1, 3'd0); line_push(8'hE2, 3'd0);
        bus(2'd3, 1'b0, 4'b0111, 1'b0, 32'd0);
        check(ak === 1'b1, "R8 beat to 63", ak, 1);
        bus(2'd0, 1'b0, 4'b0011, 1'b0, 32'd0);
        check(ak === 1'b0 && rd === 32'd0, "R8 beat past limit refused", {31'd0, ak} | rd, 0);
        bus(2'd0, 1'b0, 4'b0001, 1'b0, 32'd0);
        check(ak === 1'b1 && rd === 32'hE1, "R8 beat to exactly 64", rd, 32'hE1);
        bus(2'd0, 1'b0, 4'b0001, 1'b0, 32'd0);
        check(ak === 1'b0, "R8 beat after 64 refused", ak, 0);
        rd_chk(2'd0, 4'b0001, 32'hE2, "R8 new burst and no pop on refusal");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_tx_multi;
        t_rx_multi;
        t_rx_short;
        t_pair;
        t_legacy;
        t_ovf;
        t_burst;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule